// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port that sits on a small register bus inside a microcontroller-style core. Every pin has a direction bit, an output latch and a weak pull-up request. One active-low control bit turns on the pull-ups for all pins, but a pin that is driving as an output never gets one.

The upper four pins watch for changes. When a pin in that group is set as an input and its level differs from the value recorded at the last port access, an interrupt flag is raised. The flag stays set as long as the difference lasts, so firmware has to read or write the port before it can clear the flag. A wake request follows the change condition so that a sleeping core can be brought back.

Pin levels pass through a synchronizer before anything uses them. The bus is a plain single-cycle register interface with no back-pressure: a write takes effect at the clock edge where `bus_en` and `bus_we` are high, and read data is combinational from the address. A read strobe is a cycle where `bus_en` is high and `bus_we` is low.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the following hold:
  - every direction bit is 1 and all `pin_oe` bits are 0;
  - all output latches and `pin_out` bits are 0;
  - the change snapshot is 0;
  - the flag and `pin_pu` are 0;
  - the option register reads 0x80.
- R2: The direction register is at address 1. A 1 bit makes the pin an input (`pin_oe` low) and a 0 bit drives it (`pin_oe` high). The register reads back what was written.
- R3: A write to the port register (address 0) loads all 8 output latches whatever the direction. `pin_out` shows the new value in the following cycle. A read of address 0 returns the pin levels after the 2-stage synchronizer, not the latches.
- R4: The option register is at address 2, and its bit 7 is the active-low pull-up enable. While it is 0, `pin_pu` is high for every input pin. The other option bits read as 0.
- R5: A pin set as an output has `pin_pu` low, whatever the value of option bit 7.
- R6: A synchronized level on pins 7..4 that is set as input and differs from the snapshot sets the flag (bit 0 of address 3) at the next clock edge. Pins 3..0 never affect the flag.
- R7: An upper pin set as an output never sets the flag, whatever its level.
- R8: While a mismatch persists, writing 0 to address 3 leaves the flag set. Any read or write of address 0 copies the synchronized levels into the snapshot, and after that a write of 0 clears the flag.
- R9: If the synchronized level changes in the cycle of a port read, the read returns the new level and the flag is still set at that edge, so the change is not lost.
- R10: `wake_req` is high whenever the flag is set or a mismatch is present.
- R11: Writing 1 to bit 0 of address 3 sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 port, 1 direction, 2 option, 3 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| irq_flag | output | 1 | Port-change interrupt flag |
| wake_req | output | 1 | Wake request for a sleeping core |

## Verification
A wrong snapshot is the hardest fault to see, because it only shows up later. It appears as a flag that rises, or fails to rise, one edge after the synchronized upper-pin level is compared. It also appears as a flag that refuses to clear after a port access.

Faults in the direction register, latches or option bit show on `pin_oe`, `pin_out` and `pin_pu` in the cycle after the write. A synchronizer of the wrong depth shifts port read data by one or more cycles.

The bench compares every output against a behavioural model on every clock. It also drives a pin change timed to land in the same cycle as a port read.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_OPT  = 2'd2,
    REG_IRQ  = 2'd3
  } reg_sel_e;

  localparam int PU_BIT  = 7;
  localparam int IRQ_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_wr,
  input  logic         lat_wr,
  input  logic         opt_wr,
  input  logic [W-1:0] wdata,
  input  logic         pu_n_wdata,
  output logic [W-1:0] dir_q,
  output logic         pu_n_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  logic [W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      pu_n_q <= 1'b1;
    end else begin
      if (dir_wr) dir_q  <= wdata;
      if (lat_wr) lat_q  <= wdata;
      if (opt_wr) pu_n_q <= pu_n_wdata;
    end
  end

  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;
  assign pin_pu  = pu_n_q ? '0 : dir_q;

  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> (pin_out == $past(wdata)));
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pin_oe == ~$past(wdata)));
  p_pu_output_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0));
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] lvl_up,
  input  logic [CW-1:0] dir_up,
  input  logic          port_acc,
  input  logic          irq_wr,
  input  logic          irq_wbit,
  output logic          flag,
  output logic          mismatch
);
  logic [CW-1:0] snap_q;
  logic [CW-1:0] diff;

  assign diff     = (lvl_up ^ snap_q) & dir_up;
  assign mismatch = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (port_acc) snap_q <= lvl_up;
      if (mismatch)    flag <= 1'b1;
      else if (irq_wr) flag <= irq_wbit;
    end
  end

  p_mismatch_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch && !irq_wr) |=> (flag == $past(flag)));
  p_access_clears_mm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && $stable(lvl_up) && $stable(dir_up)) |=> $stable(lvl_up) |-> !mismatch);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu,
  output logic              irq_flag,
  output logic              wake_req
);
  localparam int CW = PORT_W - CHG_LO;

  reg_sel_e          sel;
  logic              wr, port_acc;
  logic [PORT_W-1:0] lvl_s, dir_q;
  logic              pu_n_q, mm;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr       = bus_en && bus_we;
  assign port_acc = bus_en && (sel == REG_PORT);

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
  );

  gpio_pad_ctrl #(.W(PORT_W)) u_pad (
    .clk(clk), .rst_n(rst_n),
    .dir_wr(wr && sel == REG_DIR),
    .lat_wr(wr && sel == REG_PORT),
    .opt_wr(wr && sel == REG_OPT),
    .wdata(bus_wdata), .pu_n_wdata(bus_wdata[PU_BIT]),
    .dir_q(dir_q), .pu_n_q(pu_n_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  gpio_chg_det #(.CW(CW)) u_chg (
    .clk(clk), .rst_n(rst_n),
    .lvl_up(lvl_s[PORT_W-1:CHG_LO]), .dir_up(dir_q[PORT_W-1:CHG_LO]),
    .port_acc(port_acc),
    .irq_wr(wr && sel == REG_IRQ), .irq_wbit(bus_wdata[IRQ_BIT]),
    .flag(irq_flag), .mismatch(mm)
  );

  assign wake_req = irq_flag | mm;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_PORT: bus_rdata = lvl_s;
      REG_DIR:  bus_rdata = dir_q;
      REG_OPT:  bus_rdata[PU_BIT] = pu_n_q;
      REG_IRQ:  bus_rdata[IRQ_BIT] = irq_flag;
    endcase
  end

  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(mm || (wr && sel == REG_IRQ)));
endmodule

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [7:0] pin_in = 8'h00, pin_out, pin_oe, pin_pu;
  logic       irq_flag, wake_req;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_chg_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .irq_flag(irq_flag), .wake_req(wake_req)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] hist[$] = '{8'h00, 8'h00};
  logic [7:0] m_dir = 8'hFF, m_lat = 8'h00;
  logic [3:0] m_snap = 4'h0;
  logic       m_flag = 1'b0, m_pun = 1'b1;

  function automatic logic m_mm();
    return (((hist[1][7:4] ^ m_snap) & m_dir[7:4]) != 4'h0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{8'h00, 8'h00};
      m_dir = 8'hFF; m_lat = 8'h00; m_snap = 4'h0; m_flag = 1'b0; m_pun = 1'b1;
    end else begin
      logic mm;
      mm = m_mm();
      if (mm) m_flag = 1'b1;
      else if (bus_en && bus_we && bus_addr == 2'd3) m_flag = bus_wdata[0];
      if (bus_en && bus_addr == 2'd0) m_snap = hist[1][7:4];
      if (bus_en && bus_we) begin
        case (bus_addr)
          2'd0: m_lat = bus_wdata;
          2'd1: m_dir = bus_wdata;
          2'd2: m_pun = bus_wdata[7];
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
    #5;
    begin
      logic [7:0] erd;
      case (bus_addr)
        2'd0: erd = hist[1];
        2'd1: erd = m_dir;
        2'd2: erd = {m_pun, 7'b0};
        default: erd = {7'b0, m_flag};
      endcase
      chk("R3 model rdata", bus_rdata, erd);
      chk("R2 model pin_oe", pin_oe, ~m_dir);
      chk("R3 model pin_out", pin_out, m_lat);
      chk("R5 model pin_pu", pin_pu, m_pun ? 8'h00 : m_dir);
      chk("R6 model flag", {7'b0, irq_flag}, {7'b0, m_flag});
      chk("R10 model wake", {7'b0, wake_req}, {7'b0, m_flag | m_mm()});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 pu", pin_pu, 8'h00);
    chk("R1 flag", {7'b0, irq_flag}, 8'h00);
    rd(2'd2, v); chk("R1 opt", v, 8'h80);
    rd(2'd1, v); chk("R1 dir", v, 8'hFF);

    // R2 R3 direction and latch
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h0F);
    chk("R2 oe", pin_oe, 8'hF0);
    chk("R3 out", pin_out, 8'hA5);
    rd(2'd1, v); chk("R2 dir readback", v, 8'h0F);
    pin_in = 8'h3C; idle(4);
    rd(2'd0, v); chk("R3 port read gives pins", v, 8'h3C);
    // R7 upper outputs excluded
    pin_in = 8'hCC; idle(4);
    chk("R7 no flag on output pins", {7'b0, irq_flag}, 8'h00);
    pin_in = 8'h3C; idle(3);
    rd(2'd0, v);

    // R4 R5 pull-ups
    wr(2'd2, 8'h7F);
    chk("R4 R5 pu on inputs only", pin_pu, 8'h0F);
    rd(2'd2, v); chk("R4 opt other bits zero", v, 8'h00);
    wr(2'd2, 8'h80);
    chk("R4 pu off", pin_pu, 8'h00);

    // R6 change detect
    wr(2'd1, 8'hFF);
    idle(2);
    chk("R6 no flag when equal", {7'b0, irq_flag}, 8'h00);
    pin_in = 8'h31; idle(4);
    chk("R6 lower pins ignored", {7'b0, irq_flag}, 8'h00);
    pin_in = 8'h71; idle(4);
    chk("R6 upper change sets flag", {7'b0, irq_flag}, 8'h01);
    chk("R10 wake", {7'b0, wake_req}, 8'h01);

    // R8 sticky until port access
    wr(2'd3, 8'h00);
    chk("R8 clear blocked", {7'b0, irq_flag}, 8'h01);
    rd(2'd0, v); chk("R3 read new level", v, 8'h71);
    wr(2'd3, 8'h00);
    chk("R8 clear after access", {7'b0, irq_flag}, 8'h00);
    chk("R10 wake low", {7'b0, wake_req}, 8'h00);

    // R11 software set
    wr(2'd3, 8'h01);
    chk("R11 set", {7'b0, irq_flag}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R11 clear", {7'b0, irq_flag}, 8'h00);

    // R9 change coincident with port read
    @(negedge clk);
    pin_in = 8'hF1;
    @(posedge clk); @(posedge clk);
    rd(2'd0, v);
    chk("R9 read sees new level", v, 8'hF1);
    chk("R9 flag set", {7'b0, irq_flag}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R9 mismatch ended", {7'b0, irq_flag}, 8'h00);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule